// File: doc/BRIEF.md
# Extended-Precision Operand Exception Classifier

This block sits beside the issue stage of a floating-point unit that works on 80-bit extended-precision values. Each 80-bit value has a sign bit, a 15-bit biased exponent, an explicit integer bit and a 63-bit fraction. As an instruction issues, the block takes up to two such operands. It sorts each one into an encoding class and decides whether the instruction must flag an invalid-operation exception, a denormal-operand exception, or both. The decision depends on the operand classes and on the kind of operation that will consume them.

Quiet NaNs are harmless to ordinary arithmetic. They become invalid only for comparisons and for stores that convert to integer or packed-decimal form. Signaling NaNs are always invalid. Encodings that a conforming unit never produces are rejected as invalid whenever they arrive. These are pseudo-zero, pseudo-infinity, pseudo-NaN and unnormal. When the denormal exception is masked, every denormal operand is handed on in normalized form. The block uses an exponent field two bits wider than the stored one, so the normalized value stays exact.

Results appear one clock after the request, with a valid bit alongside. The block does no arithmetic, no rounding and no exception delivery.

Top module: `xop_classify`

## Requirements
- R1: Each operand's class code on `cls_o` (4 bits per operand, operand k at bits 4k+3:4k) is computed from exponent e (bits 78:64), integer bit j (bit 63) and fraction f (bits 62:0). The codes are:
  - e all ones: j=1 with f=0 gives 4 (infinity); j=1 with bit 62 set gives 5 (quiet NaN); j=1 with bit 62 clear and f nonzero gives 6 (signaling NaN); j=0 with f=0 gives 7 (pseudo-infinity); j=0 with f nonzero gives 8 (pseudo-NaN).
  - e zero: j=1 gives 3 (pseudo-denormal); j=0 with f=0 gives 0 (zero); j=0 with f nonzero gives 2 (denormal).
  - Any other e: j=1 gives 1 (normal); j=0 with f nonzero gives 9 (unnormal); j=0 with f=0 gives 10 (pseudo-zero).
- R2: `out_valid_o` is high in exactly the cycles that follow a cycle with `in_valid_i` high. Class codes and normalized operands hold their last value when no request arrives.
- R3: A used signaling-NaN operand raises `inv_o` for every operation kind.
- R4: The operation kind on `kind_i` is coded 0 for arithmetic, 1 for compare, 2 for store-to-integer and 3 for store-to-packed-decimal. A used quiet-NaN operand raises `inv_o` for kinds 1, 2 and 3, and does not raise it for kind 0.
- R5: A used pseudo-zero, pseudo-infinity, pseudo-NaN or unnormal operand raises `inv_o` for every kind.
- R6: `den_o` is raised when any used operand is denormal or pseudo-denormal (codes 2 and 3), whatever the value of `dmask_i`.
- R7: `fault_o` is high exactly when `den_o` is high and `dmask_i` was 0 in the request cycle.
- R8: When `dmask_i` is 1 and an operand has class code 2 or 3, its significand on `nsig_o` is shifted left by its leading-zero count n so that bit 63 is set. Its exponent on `nexp_o` is the 17-bit two's-complement value 1 - n, so a pseudo-denormal gets exponent 1 and an unchanged significand.
- R9: Every other operand, and every denormal operand when `dmask_i` is 0, passes through unchanged. `nexp_o` carries the exponent zero-extended to 17 bits, `nsig_o` the 64-bit significand, and `nsgn_o` the sign in all cases.
- R10: An operand whose `use_i` bit is 0 still reports its class and normalized copy, but it raises no flag.
- R11: While `rst_ni` is low every output is zero.
- R12: In a cycle after a cycle with `in_valid_i` low, `inv_o`, `den_o` and `fault_o` are low, whatever the operand inputs held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present this cycle |
| kind_i | input | 2 | Operation kind (0 arith, 1 compare, 2 store int, 3 store decimal) |
| dmask_i | input | 1 | Denormal exception masked |
| use_i | input | 2 | Per-operand used bit |
| ops_i | input | 160 | Operands, operand k at bits 80k+79:80k |
| out_valid_o | output | 1 | Results valid |
| cls_o | output | 8 | Class codes, 4 bits per operand |
| inv_o | output | 1 | Invalid-operation flag |
| den_o | output | 1 | Denormal-operand flag |
| fault_o | output | 1 | Unmasked denormal fault request |
| nsgn_o | output | 2 | Operand signs |
| nexp_o | output | 34 | Widened exponents, 17 bits per operand, two's complement |
| nsig_o | output | 128 | Significands, 64 bits per operand |

## Verification
The bound checker watches several rules on every clock:
- the one-cycle valid latency;
- that signaling NaNs and the four rejected encodings always raise invalid;
- that arithmetic with only quiet NaNs stays clean;
- that denormal operands always raise the denormal flag, that the fault matches the flag and the mask, and that a masked denormal leaves with its top significand bit set and an exponent of at most one.

Only the bench's scenarios can show the exact class code for each encoding and the exact shift and exponent for each fraction. The same holds for the gating by the used bits and for the hold behaviour on idle cycles, since the bench compares against a reference model over every class pair under all four operation kinds.

// File: rtl/xop_pkg.sv
`timescale 1ns/1ps
package xop_pkg;

   localparam int CLS_W = 4;

   typedef enum logic [CLS_W-1:0] {
      XC_ZERO    = 4'd0,
      XC_NORMAL  = 4'd1,
      XC_DENORM  = 4'd2,
      XC_PDENORM = 4'd3,
      XC_INF     = 4'd4,
      XC_QNAN    = 4'd5,
      XC_SNAN    = 4'd6,
      XC_PINF    = 4'd7,
      XC_PNAN    = 4'd8,
      XC_UNNORM  = 4'd9,
      XC_PZERO   = 4'd10
   } xop_cls_e;

   typedef enum logic [1:0] {
      XK_ARITH   = 2'd0,
      XK_COMPARE = 2'd1,
      XK_STINT   = 2'd2,
      XK_STBCD   = 2'd3
   } xop_kind_e;

   // encodings a conforming unit never creates; always rejected
   function automatic logic is_rejected(input xop_cls_e c);
      return (c == XC_PINF) || (c == XC_PNAN) || (c == XC_UNNORM) || (c == XC_PZERO);
   endfunction

   // operands that trip the denormal-operand exception
   function automatic logic is_denormal(input xop_cls_e c);
      return (c == XC_DENORM) || (c == XC_PDENORM);
   endfunction

endpackage

// File: rtl/xop_lzc.sv
`timescale 1ns/1ps
module xop_lzc #(
   parameter int W     = 64,
   parameter bit SPLIT = 1'b1,
   localparam int CW   = $clog2(W) + 1
) (
   input  logic [W-1:0]  vec_i,
   output logic [CW-1:0] cnt_o
);

   initial begin : chk_params
      if (W < 2) $fatal(1, "xop_lzc: W must be at least 2");
   end

   generate
      if (SPLIT && (W >= 4) && (W % 2 == 0)) begin : g_split
         // two half-width scans run side by side, then one mux
         localparam int HW = W / 2;
         logic [CW-1:0] hi_c, lo_c;
         logic          hi_zero;

         always_comb begin
            hi_c = CW'(HW);
            for (int i = 0; i < HW; i++) begin
               if (vec_i[HW+i]) hi_c = CW'(HW - 1 - i);
            end
         end

         always_comb begin
            lo_c = CW'(HW);
            for (int i = 0; i < HW; i++) begin
               if (vec_i[i]) lo_c = CW'(HW - 1 - i);
            end
         end

         assign hi_zero = ~|vec_i[W-1:HW];
         assign cnt_o   = hi_zero ? (CW'(HW) + lo_c) : hi_c;
      end else begin : g_flat
         always_comb begin
            cnt_o = CW'(W);
            for (int i = 0; i < W; i++) begin
               if (vec_i[i]) cnt_o = CW'(W - 1 - i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/xop_class_decode.sv
`timescale 1ns/1ps
module xop_class_decode
   import xop_pkg::*;
#(
   parameter int EXP_W = 15,
   parameter int SIG_W = 64
) (
   input  logic [EXP_W+SIG_W-1:0] mag_i,   // exponent and significand, no sign
   output xop_cls_e               cls_o
);

   initial begin : chk_params
      if (EXP_W < 2) $fatal(1, "xop_class_decode: EXP_W too small");
      if (SIG_W < 3) $fatal(1, "xop_class_decode: SIG_W too small");
   end

   logic [EXP_W-1:0] bexp;
   logic             jbit;
   logic [SIG_W-2:0] frac;
   logic             e_ones, e_zero, f_zero, quiet;

   assign bexp   = mag_i[SIG_W +: EXP_W];
   assign jbit   = mag_i[SIG_W-1];
   assign frac   = mag_i[SIG_W-2:0];
   assign e_ones = &bexp;
   assign e_zero = ~|bexp;
   assign f_zero = ~|frac;
   assign quiet  = frac[SIG_W-2];

   always_comb begin
      if (e_ones) begin
         if (jbit) begin
            if (f_zero)     cls_o = XC_INF;
            else if (quiet) cls_o = XC_QNAN;
            else            cls_o = XC_SNAN;
         end else begin
            cls_o = f_zero ? XC_PINF : XC_PNAN;
         end
      end else if (e_zero) begin
         if (jbit)        cls_o = XC_PDENORM;
         else if (f_zero) cls_o = XC_ZERO;
         else             cls_o = XC_DENORM;
      end else begin
         if (jbit)        cls_o = XC_NORMAL;
         else if (f_zero) cls_o = XC_PZERO;
         else             cls_o = XC_UNNORM;
      end
   end

endmodule

// File: rtl/xop_norm.sv
`timescale 1ns/1ps
module xop_norm
   import xop_pkg::*;
#(
   parameter int EXP_W     = 15,
   parameter int SIG_W     = 64,
   parameter int NEXP_W    = EXP_W + 2,
   parameter bit LZC_SPLIT = 1'b1,
   localparam int OP_W     = 1 + EXP_W + SIG_W
) (
   input  logic [OP_W-1:0]   op_i,
   input  xop_cls_e          cls_i,
   input  logic              dmask_i,
   output logic              sgn_o,
   output logic [NEXP_W-1:0] exp_o,
   output logic [SIG_W-1:0]  sig_o
);

   localparam int CNT_W = $clog2(SIG_W) + 1;

   initial begin : chk_params
      if (NEXP_W <= EXP_W)  $fatal(1, "xop_norm: widened exponent must exceed stored one");
      if (NEXP_W <= CNT_W)  $fatal(1, "xop_norm: widened exponent cannot hold the shift");
   end

   logic [EXP_W-1:0] bexp;
   logic [SIG_W-1:0] sig;
   logic [CNT_W-1:0] lz;

   assign bexp = op_i[SIG_W +: EXP_W];
   assign sig  = op_i[SIG_W-1:0];

   xop_lzc #(
      .W     (SIG_W),
      .SPLIT (LZC_SPLIT)
   ) i_lzc (
      .vec_i (sig),
      .cnt_o (lz)
   );

   always_comb begin
      sgn_o = op_i[OP_W-1];
      if (dmask_i && is_denormal(cls_i)) begin
         // internal exponent of a denormal is 1; each shift step lowers it by one
         sig_o = sig << lz;
         exp_o = NEXP_W'(1) - NEXP_W'(lz);
      end else begin
         sig_o = sig;
         exp_o = NEXP_W'(bexp);
      end
   end

endmodule

// File: rtl/xop_classify.sv
`timescale 1ns/1ps
module xop_classify
   import xop_pkg::*;
#(
   parameter int NUM_OPS   = 2,
   parameter int EXP_W     = 15,
   parameter int SIG_W     = 64,
   parameter bit LZC_SPLIT = 1'b1,
   localparam int OP_W     = 1 + EXP_W + SIG_W,
   localparam int NEXP_W   = EXP_W + 2
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic                      in_valid_i,
   input  logic [1:0]                kind_i,
   input  logic                      dmask_i,
   input  logic [NUM_OPS-1:0]        use_i,
   input  logic [NUM_OPS*OP_W-1:0]   ops_i,
   output logic                      out_valid_o,
   output logic [NUM_OPS*CLS_W-1:0]  cls_o,
   output logic                      inv_o,
   output logic                      den_o,
   output logic                      fault_o,
   output logic [NUM_OPS-1:0]        nsgn_o,
   output logic [NUM_OPS*NEXP_W-1:0] nexp_o,
   output logic [NUM_OPS*SIG_W-1:0]  nsig_o
);

   initial begin : chk_params
      if (NUM_OPS < 1 || NUM_OPS > 4) $fatal(1, "xop_classify: NUM_OPS out of range");
      if (EXP_W < 4)                  $fatal(1, "xop_classify: EXP_W too small");
      if (SIG_W < 8)                  $fatal(1, "xop_classify: SIG_W too small");
   end

   logic [NUM_OPS*CLS_W-1:0]  cls_c;
   logic [NUM_OPS-1:0]        sgn_c;
   logic [NUM_OPS*NEXP_W-1:0] exp_c;
   logic [NUM_OPS*SIG_W-1:0]  sig_c;
   logic [NUM_OPS-1:0]        snan_v, qnan_v, rej_v, den_v;
   logic                      qnan_hurts;
   logic                      inv_c, den_c, fault_c;

   generate
      for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
         logic [OP_W-1:0] op;
         xop_cls_e        cls;

         assign op = ops_i[k*OP_W +: OP_W];

         xop_class_decode #(
            .EXP_W (EXP_W),
            .SIG_W (SIG_W)
         ) i_dec (
            .mag_i (op[OP_W-2:0]),
            .cls_o (cls)
         );

         xop_norm #(
            .EXP_W     (EXP_W),
            .SIG_W     (SIG_W),
            .NEXP_W    (NEXP_W),
            .LZC_SPLIT (LZC_SPLIT)
         ) i_norm (
            .op_i    (op),
            .cls_i   (cls),
            .dmask_i (dmask_i),
            .sgn_o   (sgn_c[k]),
            .exp_o   (exp_c[k*NEXP_W +: NEXP_W]),
            .sig_o   (sig_c[k*SIG_W +: SIG_W])
         );

         assign cls_c[k*CLS_W +: CLS_W] = cls;
         assign snan_v[k] = use_i[k] && (cls == XC_SNAN);
         assign qnan_v[k] = use_i[k] && (cls == XC_QNAN);
         assign rej_v[k]  = use_i[k] && is_rejected(cls);
         assign den_v[k]  = use_i[k] && is_denormal(cls);
      end
   endgenerate

   // quiet NaNs only matter where the operation cannot propagate them
   assign qnan_hurts = (xop_kind_e'(kind_i) != XK_ARITH);
   assign inv_c      = (|snan_v) || (|rej_v) || ((|qnan_v) && qnan_hurts);
   assign den_c      = |den_v;
   assign fault_c    = den_c && !dmask_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_valid_o <= 1'b0;
         inv_o       <= 1'b0;
         den_o       <= 1'b0;
         fault_o     <= 1'b0;
         cls_o       <= '0;
         nsgn_o      <= '0;
         nexp_o      <= '0;
         nsig_o      <= '0;
      end else begin
         out_valid_o <= in_valid_i;
         if (in_valid_i) begin
            inv_o   <= inv_c;
            den_o   <= den_c;
            fault_o <= fault_c;
            cls_o   <= cls_c;
            nsgn_o  <= sgn_c;
            nexp_o  <= exp_c;
            nsig_o  <= sig_c;
         end else begin
            inv_o   <= 1'b0;
            den_o   <= 1'b0;
            fault_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/xop_classify_chk.sv
`timescale 1ns/1ps
module xop_classify_chk
   import xop_pkg::*;
#(
   parameter int NUM_OPS  = 2,
   parameter int EXP_W    = 15,
   parameter int SIG_W    = 64,
   localparam int NEXP_W  = EXP_W + 2
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic                      in_valid_i,
   input logic [1:0]                kind_i,
   input logic                      dmask_i,
   input logic [NUM_OPS-1:0]        use_i,
   input logic                      out_valid_o,
   input logic [NUM_OPS*CLS_W-1:0]  cls_o,
   input logic                      inv_o,
   input logic                      den_o,
   input logic                      fault_o,
   input logic [NUM_OPS*NEXP_W-1:0] nexp_o,
   input logic [NUM_OPS*SIG_W-1:0]  nsig_o
);

   logic [NUM_OPS-1:0] use_q;
   logic [1:0]         kind_q;
   logic               dmask_q;
   logic [NUM_OPS-1:0] trips;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         use_q   <= '0;
         kind_q  <= 2'd0;
         dmask_q <= 1'b0;
      end else if (in_valid_i) begin
         use_q   <= use_i;
         kind_q  <= kind_i;
         dmask_q <= dmask_i;
      end
   end

   p_lat_up_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid_i |=> out_valid_o);
   p_lat_dn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i |=> !out_valid_o);
   p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_valid_o |-> (!inv_o && !den_o && !fault_o));
   p_fault_match_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o |-> (fault_o == (den_o && !dmask_q)));
   p_unused_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && (use_q == '0)) |-> (!inv_o && !den_o));

   generate
      for (genvar k = 0; k < NUM_OPS; k++) begin : g_chk
         xop_cls_e                 c;
         logic signed [NEXP_W-1:0] ex;
         logic [SIG_W-1:0]         sg;

         assign c  = xop_cls_e'(cls_o[k*CLS_W +: CLS_W]);
         assign ex = nexp_o[k*NEXP_W +: NEXP_W];
         assign sg = nsig_o[k*SIG_W +: SIG_W];
         assign trips[k] = use_q[k] && ((c == XC_SNAN) || is_rejected(c));

         p_snan_inv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (out_valid_o && use_q[k] && (c == XC_SNAN)) |-> inv_o);
         p_reject_inv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (out_valid_o && use_q[k] && is_rejected(c)) |-> inv_o);
         p_den_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (out_valid_o && use_q[k] && is_denormal(c)) |-> den_o);
         p_norm_shape_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (out_valid_o && dmask_q && is_denormal(c)) |-> (sg[SIG_W-1] && (ex <= 1)));
      end
   endgenerate

   p_qnan_arith_clean_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && (kind_q == 2'd0) && (trips == '0)) |-> !inv_o);

endmodule

bind xop_classify xop_classify_chk #(
   .NUM_OPS (NUM_OPS),
   .EXP_W   (EXP_W),
   .SIG_W   (SIG_W)
) i_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .in_valid_i  (in_valid_i),
   .kind_i      (kind_i),
   .dmask_i     (dmask_i),
   .use_i       (use_i),
   .out_valid_o (out_valid_o),
   .cls_o       (cls_o),
   .inv_o       (inv_o),
   .den_o       (den_o),
   .fault_o     (fault_o),
   .nexp_o      (nexp_o),
   .nsig_o      (nsig_o)
);

// File: tb/test_xop_classify.sv
`timescale 1ns/1ps
module test_xop_classify;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [1:0]   kind = 2'd0;
   logic         dmask = 1'b0;
   logic [1:0]   use_b = 2'b00;
   logic [159:0] ops = '0;
   logic         out_valid;
   logic [7:0]   cls;
   logic         inv, den, flt;
   logic [1:0]   nsgn;
   logic [33:0]  nexp;
   logic [127:0] nsig;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   xop_classify i_xop_classify (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .in_valid_i  (in_valid),
      .kind_i      (kind),
      .dmask_i     (dmask),
      .use_i       (use_b),
      .ops_i       (ops),
      .out_valid_o (out_valid),
      .cls_o       (cls),
      .inv_o       (inv),
      .den_o       (den),
      .fault_o     (flt),
      .nsgn_o      (nsgn),
      .nexp_o      (nexp),
      .nsig_o      (nsig)
   );

   typedef struct packed {
      logic         vld;
      logic [7:0]   cls;
      logic         inv, den, flt;
      logic [1:0]   sgn;
      logic [33:0]  nexp;
      logic [127:0] nsig;
   } expect_t;

   expect_t exq[$];
   expect_t held = '0;

   // class codes written straight from R1
   function automatic logic [3:0] ref_cls(input logic [79:0] op);
      logic [14:0] e = op[78:64];
      logic        j = op[63];
      logic [62:0] f = op[62:0];
      if (e == 15'h7FFF) begin
         if (j) return (f == 0) ? 4'd4 : (f[62] ? 4'd5 : 4'd6);
         return (f == 0) ? 4'd7 : 4'd8;
      end
      if (e == 0) return j ? 4'd3 : ((f == 0) ? 4'd0 : 4'd2);
      return j ? 4'd1 : ((f == 0) ? 4'd10 : 4'd9);
   endfunction

   // R8 / R9: shift until the top bit is set, counting steps
   function automatic void ref_norm(input logic [79:0] op, input logic [3:0] c, input logic dm,
                                    output logic [16:0] ex, output logic [63:0] sg);
      int n = 0;
      sg = op[63:0];
      if (dm && (c == 4'd2 || c == 4'd3)) begin
         while (!sg[63]) begin
            sg = sg << 1;
            n++;
         end
         ex = 17'(1 - n);
      end else begin
         ex = {2'b00, op[78:64]};
      end
   endfunction

   // reference model: one expectation per rising edge
   always @(posedge clk) begin : model
      expect_t nx;
      if (!rst_n) begin
         held = '0;
         exq.push_back('0);           // R11
      end else begin
         nx = held;
         nx.vld = in_valid;
         nx.inv = 1'b0;
         nx.den = 1'b0;
         nx.flt = 1'b0;
         if (in_valid) begin
            for (int k = 0; k < 2; k++) begin
               logic [79:0] op;
               logic [3:0]  c;
               logic [16:0] ex;
               logic [63:0] sg;
               op = ops[k*80 +: 80];
               c  = ref_cls(op);
               ref_norm(op, c, dmask, ex, sg);
               nx.cls[k*4 +: 4]    = c;
               nx.sgn[k]           = op[79];
               nx.nexp[k*17 +: 17] = ex;
               nx.nsig[k*64 +: 64] = sg;
               if (use_b[k]) begin
                  if (c == 4'd6) nx.inv = 1'b1;                                  // R3
                  if (c == 4'd5 && kind != 2'd0) nx.inv = 1'b1;                  // R4
                  if (c == 4'd7 || c == 4'd8 || c == 4'd9 || c == 4'd10) nx.inv = 1'b1; // R5
                  if (c == 4'd2 || c == 4'd3) nx.den = 1'b1;                     // R6
               end
            end
            nx.flt = nx.den && !dmask;                                           // R7
         end
         held = nx;
         exq.push_back(nx);
      end
   end

   task automatic check(input string tag, input logic [127:0] act, input logic [127:0] want);
      n_checks++;
      if (act !== want) begin
         n_errors++;
         $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, want);
      end
   endtask

   always @(negedge clk) begin : compare
      expect_t e;
      if (exq.size() > 0) begin
         e = exq.pop_front();
         if (!rst_n) begin
            check("R11 reset outputs", {out_valid, inv, den, flt, cls, nsgn, nexp},
                  {1'b0, 3'b000, 8'h0, 2'b00, 34'h0});
            check("R11 reset significands", nsig, '0);
         end else begin
            check("R2 out_valid", out_valid, e.vld);
            check("R1 class codes", cls, e.cls);
            if (!e.vld) check("R12 flags idle", {inv, den, flt}, 3'b000);
            check("R3/R4/R5/R10 invalid flag", inv, e.inv);
            check("R6/R10 denormal flag", den, e.den);
            check("R7 fault request", flt, e.flt);
            check("R9 signs", nsgn, e.sgn);
            check("R8/R9 exponents", nexp, e.nexp);
            check("R8/R9 significands", nsig, e.nsig);
         end
      end
   end

   function automatic logic [79:0] mk(input int c);
      logic        s = 1'($urandom);
      logic [14:0] e = 15'($urandom_range(1, 32766));
      logic [62:0] f = 63'({$urandom, $urandom});
      f = f >> ($urandom % 63);
      if (f == 0) f = 63'd1;
      case (c)
         0:  return {s, 15'h0, 1'b0, 63'h0};
         1:  return {s, e, 1'b1, f};
         2:  return {s, 15'h0, 1'b0, f};
         3:  return {s, 15'h0, 1'b1, f};
         4:  return {s, 15'h7FFF, 1'b1, 63'h0};
         5:  return {s, 15'h7FFF, 1'b1, f | (63'd1 << 62)};
         6:  begin
                f[62] = 1'b0;
                if (f == 0) f = 63'd3;
                return {s, 15'h7FFF, 1'b1, f};
             end
         7:  return {s, 15'h7FFF, 1'b0, 63'h0};
         8:  return {s, 15'h7FFF, 1'b0, f};
         9:  return {s, e, 1'b0, f};
         default: return {s, e, 1'b0, 63'h0};
      endcase
   endfunction

   task automatic drive(input logic [1:0] k, input logic dm, input logic [1:0] u,
                        input logic [79:0] a, input logic [79:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      kind     = k;
      dmask    = dm;
      use_b    = u;
      ops      = {b, a};
   endtask

   // R12: idle cycles carry junk operands that must raise nothing
   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      kind     = 2'($urandom);
      dmask    = 1'($urandom);
      use_b    = 2'b11;
      ops      = {mk(6), mk(8)};
   endtask

   initial begin : stim
      repeat (3) @(negedge clk);     // R11 checked while held in reset
      rst_n = 1'b1;
      idle();
      idle();
      // R1, R3, R4, R5, R6, R7, R8, R9: every class pair under every kind
      for (int k = 0; k < 4; k++) begin
         for (int a = 0; a < 11; a++) begin
            for (int b = 0; b < 11; b++) begin
               drive(2'(k), 1'((a + b + k) % 2), 2'b11, mk(a), mk(b));
            end
         end
      end
      idle();
      // R8: smallest denormal needs the full 63-place shift, exponent -62
      drive(2'd0, 1'b1, 2'b11, {1'b0, 15'h0, 1'b0, 63'd1}, {1'b1, 15'h0, 1'b1, 63'd5});
      // R9: same operands with the exception unmasked stay as loaded
      drive(2'd0, 1'b0, 2'b11, {1'b0, 15'h0, 1'b0, 63'd1}, {1'b1, 15'h0, 1'b1, 63'd5});
      // R4: lone quiet NaN under arithmetic, then under compare
      drive(2'd0, 1'b1, 2'b01, mk(5), mk(1));
      drive(2'd1, 1'b1, 2'b01, mk(5), mk(1));
      // R10: unused signaling NaN and unused denormal raise nothing
      drive(2'd2, 1'b0, 2'b00, mk(6), mk(2));
      drive(2'd3, 1'b0, 2'b10, mk(9), mk(0));
      // R2, R12, R10: random mix with gaps and back-to-back requests
      for (int i = 0; i < 400; i++) begin
         if ($urandom % 4 == 0) idle();
         else drive(2'($urandom), 1'($urandom), 2'($urandom),
                    mk($urandom % 11), mk($urandom % 11));
      end
      idle();
      idle();
      idle();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL R2 watchdog: actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
         $finish;
      end
   end

endmodule